// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a single 16-bit timer channel. It has one up-counter and four general registers. The counter advances on a tick taken from one of five sources: the system clock, the system clock divided by 2, 4 or 8, or the rising edges of a synchronized external clock pin. When the counter is stopped it holds its value, and it can be loaded from the register port at any time.

Each general register has its own pin and its own mode.
- In compare mode it drives its pin. On every counter tick at which the counter equals the register, it applies the selected action: hold, drive low, drive high or toggle.
- In capture mode it watches its synchronized input pin. On the selected edge or edges it latches the counter value.

One register can also be chosen to clear the counter when it matches or captures. The lower half of the registers can each be paired with a partner in the upper half, and the partner then serves as a buffer:
- A capture pushes the previous captured value into the partner.
- A compare match reloads the register from the partner.

Software reaches the block through a simple word-wide write/read port. Reads are returned one cycle after the address is presented. Pin levels can be preset while the counter is stopped.

Top module: `cc_timer_chan`

## Requirements
- R1: The counter is 16 bits wide, loads from a write to address 1, reads back at address 1, and wraps from 0xFFFF to 0x0000 on a tick. General registers 0..3 read and write at addresses 8..11.
- R2: Control address 0 holds the fields run at bit 0, source at bits 3:1, clear select at bits 6:4 and buffer enables at bits 8:7. With run set and source k in 0..3, the counter advances once every 2^k system clocks. A run span covering n clock edges yields floor(n/2^k) increments.
- R3: With source 4, the counter advances once for each rising edge of the external clock pin, after a two-flop synchronizer.
- R4: Mode registers sit at addresses 4..7. In each one, bit 0 set means compare, and bits 2:1 give the match action: 0 hold, 1 drive low, 2 drive high, 3 toggle. A compare register's enable output is high.
- R5: A capture register (mode bit 0 clear) latches the counter on the synchronized pin edge selected by mode bits 4:3: 0 none, 1 rising, 2 falling, 3 both.
- R6: Address 2 holds the flags: match flags in bits 3:0 and capture flags in bits 7:4. A flag is set by its event. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R7: When the clear select is s in 1..4, a compare match of register s-1 returns the counter to 0 instead of incrementing it. The count then cycles with period GR+1.
- R8: When the clear select names a capture register, a capture on that register sets the counter to 0 in the same cycle as the latch.
- R9: When buffer enable bit p (p in 0..1) is set, a capture on register p moves the old value of register p into register p+2.
- R10: When buffer enable bit p is set, a compare match on register p reloads register p from register p+2. Register p+2 then performs no compare or capture of its own.
- R11: A write to address 3 presets the pin levels (bit j goes to pin j) only while run is clear. While run is set, such a write is ignored. Address 3 reads back the pin levels.
- R12: After reset, all registers, flags, pins and pin enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the address |
| ext_clk | input | 1 | External count source, asynchronous |
| cc_in | input | 4 | Capture inputs, one per general register, asynchronous |
| cc_out | output | 4 | Compare output levels, one per general register |
| cc_oe | output | 4 | High where the register is in compare mode |

## Verification
Several kinds of wrong internal state show up at the ports, each at a predictable time:
- A wrong prescaler phase or divider mask makes the counter readback differ from floor(n/2^k). This shows on the read that directly follows a stop.
- A bad synchronizer or edge detector shows up as a missing or duplicated capture. It is visible within five clocks of the pin change, both as a wrong register value and as a wrong capture flag.
- Faults in buffer pairing or clear-select wiring show up in the value of the partner register, or in a counter that does not fold back at GR+1. The boundary runs stop exactly one tick before and exactly on the reload edge, so an off-by-one tick is caught by a single readback.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } cmp_act_e;

  // Bit 0 selects the rising edge and bit 1 the falling edge, so the
  // code can be used directly as a mask over {fall, rise}.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } cap_edge_e;

  typedef struct packed {
    cap_edge_e edge_sel;  // [4:3]
    cmp_act_e  act;       // [2:1]
    logic      is_cmp;    // [0]
  } slot_mode_t;

  localparam int MODE_W  = 5;

  // control word layout
  localparam int CTL_RUN = 0;
  localparam int CTL_SRC = 1;  // 3 bits
  localparam int CTL_CLR = 4;  // 3 bits
  localparam int CTL_BUF = 7;  // one bit per register pair

  // address map (general registers follow the mode registers)
  localparam int A_CTRL  = 0;
  localparam int A_CNT   = 1;
  localparam int A_FLAG  = 2;
  localparam int A_PIN   = 3;
  localparam int A_MODE  = 4;

endpackage

// File: rtl/cct_pin_sync.sv
module cct_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  output logic [1:0] edges   // {fall, rise}
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign edges = { ~sh_q[STAGES-1] &  sh_q[STAGES],
                    sh_q[STAGES-1] & ~sh_q[STAGES] };

endmodule

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
  parameter int NDIV   = 4,
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] src_sel,
  input  logic       ext_clk,
  output logic       tick
);

  localparam int PRE_W = (NDIV > 1) ? NDIV - 1 : 1;
  localparam logic [1:0] EXT_EDGE = 2'b01;

  logic [PRE_W-1:0] pre_q;
  logic [1:0]       ext_edges;
  logic             int_tick;

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  cct_pin_sync #(.STAGES(STAGES)) u_ext_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (ext_clk),
    .edges (ext_edges)
  );

  always_comb begin
    int_tick = 1'b0;
    for (int k = 0; k < NDIV; k++) begin
      if (src_sel == 3'(k))
        int_tick = ((pre_q & PRE_W'((1 << k) - 1)) == PRE_W'((1 << k) - 1));
    end
  end

  assign tick = run && ((src_sel < 3'(NDIV)) ? int_tick
                        : (src_sel == 3'(NDIV)) && |(ext_edges & EXT_EDGE));

  AST_DIV2_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && src_sel == 3'd1) |=> (!tick || src_sel != 3'd1)); // R2

endmodule

// File: rtl/cct_slot.sv
module cct_slot
  import cct_pkg::*;
#(
  parameter int CW     = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              func_en,
  input  logic [CW-1:0]     count,
  input  logic [CW-1:0]     gr,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              preset_we,
  input  logic              preset_val,
  input  logic              clr_match,
  input  logic              clr_capt,
  input  logic              pin_in,
  output logic [MODE_W-1:0] mode_bits,
  output logic              match_evt,
  output logic              capt_evt,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              match_flag,
  output logic              capt_flag
);

  slot_mode_t mode_q;
  logic [1:0] in_edges;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_we) mode_q <= slot_mode_t'(mode_wdata);
  end
  assign mode_bits = mode_q;

  cct_pin_sync #(.STAGES(STAGES)) u_in_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (pin_in),
    .edges (in_edges)
  );

  assign match_evt = func_en && mode_q.is_cmp && tick && (count == gr);
  assign capt_evt  = func_en && !mode_q.is_cmp && |(in_edges & 2'(mode_q.edge_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
    end else if (match_evt) begin
      case (mode_q.act)
        ACT_LOW:    pin_out <= 1'b0;
        ACT_HIGH:   pin_out <= 1'b1;
        ACT_TOGGLE: pin_out <= ~pin_out;
        default:    pin_out <= pin_out;
      endcase
    end else if (preset_we && !run) begin
      pin_out <= preset_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe     <= 1'b0;
      match_flag <= 1'b0;
      capt_flag  <= 1'b0;
    end else begin
      pin_oe     <= mode_q.is_cmp;
      match_flag <= match_evt | (match_flag & ~clr_match);
      capt_flag  <= capt_evt  | (capt_flag  & ~clr_capt);
    end
  end

  AST_PRESET_LOCK: assert property (@(posedge clk) disable iff (rst)
    (run && !match_evt) |=> $stable(pin_out)); // R11
  AST_CAPT_FLAG: assert property (@(posedge clk) disable iff (rst)
    capt_evt |=> capt_flag); // R5
  AST_MATCH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(match_flag) |-> $past(tick)); // R6

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cct_pkg::*;
#(
  parameter int CW     = 16,
  parameter int NREG   = 4,
  parameter int AW     = 4,
  parameter int NDIV   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic            ext_clk,
  input  logic [NREG-1:0] cc_in,
  output logic [NREG-1:0] cc_out,
  output logic [NREG-1:0] cc_oe
);

  localparam int NPAIR  = NREG / 2;
  localparam int CTRL_W = CTL_BUF + NPAIR;
  localparam int A_GR   = A_MODE + NREG;

  logic [CTRL_W-1:0]           ctrl_q;
  logic [CW-1:0]               count_q;
  logic [CW-1:0]               rd_mux;
  logic                        run, tick, clear_evt, cnt_we, flag_we;
  logic [2:0]                  src_sel, clr_sel;
  logic [NPAIR-1:0]            buf_en;
  logic [NREG-1:0]             match_evt, capt_evt, match_flag, capt_flag;
  logic [NREG-1:0][CW-1:0]     gr_v;
  logic [NREG-1:0][MODE_W-1:0] mode_v;

  assign run     = ctrl_q[CTL_RUN];
  assign src_sel = ctrl_q[CTL_SRC +: 3];
  assign clr_sel = ctrl_q[CTL_CLR +: 3];
  assign buf_en  = ctrl_q[CTL_BUF +: NPAIR];
  assign cnt_we  = bus_we && (bus_addr == AW'(A_CNT));
  assign flag_we = bus_we && (bus_addr == AW'(A_FLAG));

  always_ff @(posedge clk) begin
    if (rst)                                      ctrl_q <= '0;
    else if (bus_we && bus_addr == AW'(A_CTRL))   ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  cct_tick_gen #(.NDIV(NDIV), .STAGES(STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .src_sel (src_sel),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  always_comb begin
    clear_evt = 1'b0;
    for (int j = 0; j < NREG; j++)
      if (clr_sel == 3'(j + 1)) clear_evt = match_evt[j] | capt_evt[j];
  end

  always_ff @(posedge clk) begin
    if (rst)            count_q <= '0;
    else if (cnt_we)    count_q <= bus_wdata;
    else if (clear_evt) count_q <= '0;
    else if (tick)      count_q <= count_q + 1'b1;
  end

  for (genvar j = 0; j < NREG; j++) begin : g_reg
    logic [CW-1:0] gr_r;
    logic          gr_we, func_en;

    assign gr_we = bus_we && (bus_addr == AW'(A_GR + j));

    if (j < NPAIR) begin : g_main
      assign func_en = 1'b1;
      always_ff @(posedge clk) begin
        if (rst)                             gr_r <= '0;
        else if (capt_evt[j])                gr_r <= count_q;
        else if (match_evt[j] && buf_en[j])  gr_r <= gr_v[j+NPAIR];
        else if (gr_we)                      gr_r <= bus_wdata;
      end
      AST_BUF_PUSH: assert property (@(posedge clk) disable iff (rst)
        (buf_en[j] && capt_evt[j]) |=> (gr_v[j+NPAIR] == $past(gr_v[j]))); // R9
    end else begin : g_buf
      assign func_en = !buf_en[j-NPAIR];
      always_ff @(posedge clk) begin
        if (rst)                                          gr_r <= '0;
        else if (capt_evt[j])                             gr_r <= count_q;
        else if (buf_en[j-NPAIR] && capt_evt[j-NPAIR])    gr_r <= gr_v[j-NPAIR];
        else if (gr_we)                                   gr_r <= bus_wdata;
      end
    end

    assign gr_v[j] = gr_r;

    cct_slot #(.CW(CW), .STAGES(STAGES)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .run        (run),
      .func_en    (func_en),
      .count      (count_q),
      .gr         (gr_r),
      .mode_we    (bus_we && (bus_addr == AW'(A_MODE + j))),
      .mode_wdata (bus_wdata[MODE_W-1:0]),
      .preset_we  (bus_we && (bus_addr == AW'(A_PIN))),
      .preset_val (bus_wdata[j]),
      .clr_match  (flag_we && bus_wdata[j]),
      .clr_capt   (flag_we && bus_wdata[NREG+j]),
      .pin_in     (cc_in[j]),
      .mode_bits  (mode_v[j]),
      .match_evt  (match_evt[j]),
      .capt_evt   (capt_evt[j]),
      .pin_out    (cc_out[j]),
      .pin_oe     (cc_oe[j]),
      .match_flag (match_flag[j]),
      .capt_flag  (capt_flag[j])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(A_CTRL)) rd_mux = CW'(ctrl_q);
    if (bus_addr == AW'(A_CNT))  rd_mux = count_q;
    if (bus_addr == AW'(A_FLAG)) rd_mux = CW'({capt_flag, match_flag});
    if (bus_addr == AW'(A_PIN))  rd_mux = CW'(cc_out);
    for (int j = 0; j < NREG; j++) begin
      if (bus_addr == AW'(A_MODE + j)) rd_mux = CW'(mode_v[j]);
      if (bus_addr == AW'(A_GR + j))   rd_mux = gr_v[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear_evt && !cnt_we) |=> $stable(count_q)); // R1
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clear_evt && !cnt_we) |=> (count_q == '0)); // R7
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick); // R2

endmodule

// File: tb/cc_timer_chan_bench.sv
`timescale 1ns/1ps
module cc_timer_chan_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_clk = 1'b0;
  logic [3:0]  cc_in = '0;
  logic [3:0]  cc_out, cc_oe;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cc_timer_chan u_cc_timer_chan (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .cc_in(cc_in), .cc_out(cc_out), .cc_oe(cc_oe)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // counter runs for w+2 clock edges, then run is cleared
  task automatic run_span(input logic [15:0] ctl, input int w);
    wr(4'd0, ctl | 16'd1);
    idle(w);
    wr(4'd0, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, ca, cb, e1, e2;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R12 reset state
    rd(4'd0, v); chk("R12 ctrl", v, 16'h0);
    rd(4'd1, v); chk("R12 count", v, 16'h0);
    rd(4'd2, v); chk("R12 flags", v, 16'h0);
    rd(4'd3, v); chk("R12 pins", v, 16'h0);
    chk("R12 cc_out/cc_oe", {8'h0, cc_oe, cc_out}, 16'h0);

    // R1 load, readback, wrap
    wr(4'd1, 16'hA5C3); rd(4'd1, v); chk("R1 count load", v, 16'hA5C3);
    wr(4'd10, 16'h1357); rd(4'd10, v); chk("R1 GR2 load", v, 16'h1357);
    wr(4'd1, 16'hFFFE); run_span(16'h0, 1);
    rd(4'd1, v); chk("R1 wrap", v, 16'h0001);

    // R2 divider sweep
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 10; w++) begin
        wr(4'd1, 16'h0);
        run_span(16'(k << 1), w);
        rd(4'd1, v);
        chk($sformatf("R2 src %0d span %0d", k, w), v, 16'((w + 2) >> k));
      end
    end

    // R3 external clock pulses
    for (int np = 1; np <= 3; np++) begin
      wr(4'd1, 16'h0);
      wr(4'd0, 16'h9);  // run, source 4
      for (int p = 0; p < np; p++) begin
        @(negedge clk); ext_clk = 1'b1; idle(3);
        ext_clk = 1'b0; idle(3);
      end
      idle(4);
      wr(4'd0, 16'h0);
      rd(4'd1, v); chk($sformatf("R3 %0d pulses", np), v, 16'(np));
    end

    // R11 preset only when stopped
    wr(4'd3, 16'h000A);
    rd(4'd3, v); chk("R11 preset readback", v, 16'h000A);
    chk("R11 preset pins", {12'h0, cc_out}, 16'h000A);
    wr(4'd0, 16'h1);
    wr(4'd3, 16'h0005);
    idle(2);
    chk("R11 preset ignored while running", {12'h0, cc_out}, 16'h000A);
    wr(4'd0, 16'h0);

    // R4 compare actions
    wr(4'd3, 16'h0005);
    wr(4'd4, 16'h3); wr(4'd5, 16'h5); wr(4'd6, 16'h1); wr(4'd7, 16'h7);
    for (int j = 0; j < 4; j++) wr(4'(8 + j), 16'd4);
    wr(4'd1, 16'h0);
    run_span(16'h0, 10);
    chk("R4 actions", {12'h0, cc_out}, 16'h000E);
    chk("R4 oe", {12'h0, cc_oe}, 16'h000F);

    // R6 match flags and write-1-to-clear
    rd(4'd2, v); chk("R6 match flags set", v, 16'h000F);
    wr(4'd2, 16'h0003); rd(4'd2, v); chk("R6 clear low pair", v, 16'h000C);
    wr(4'd2, 16'h0000); rd(4'd2, v); chk("R6 zero write no effect", v, 16'h000C);
    wr(4'd2, 16'h000C); rd(4'd2, v); chk("R6 clear rest", v, 16'h0000);

    // R7 clear on compare match of register 0
    for (int j = 0; j < 4; j++) wr(4'(4 + j), 16'h0);
    wr(4'd4, 16'h1); wr(4'd8, 16'd5);
    for (int w = 0; w < 13; w++) begin
      wr(4'd1, 16'h0);
      run_span(16'(1 << 4), w);
      rd(4'd1, v); chk($sformatf("R7 span %0d", w), v, 16'((w + 2) % 6));
    end
    wr(4'd4, 16'h0);
    wr(4'd2, 16'h00FF);

    // R5 capture edge selection, counter stopped
    for (int e = 0; e < 4; e++) begin
      ca = 16'h1000 + 16'(e * 16'h11);
      cb = 16'h2000 + 16'(e * 16'h11);
      wr(4'd9, 16'h0);
      wr(4'd5, 16'(e << 3));
      wr(4'd1, ca);
      @(negedge clk); cc_in[1] = 1'b1; idle(5);
      e1 = (e[0]) ? ca : 16'h0;
      rd(4'd9, v); chk($sformatf("R5 edge %0d after rise", e), v, e1);
      wr(4'd1, cb);
      @(negedge clk); cc_in[1] = 1'b0; idle(5);
      e2 = (e[1]) ? cb : e1;
      rd(4'd9, v); chk($sformatf("R5 edge %0d after fall", e), v, e2);
      rd(4'd2, v); chk($sformatf("R6 capture flag edge %0d", e), v, (e != 0) ? 16'h0020 : 16'h0);
      wr(4'd2, 16'h00FF);
    end

    // R8 clear on capture of register 1
    wr(4'd5, 16'h8);
    wr(4'd0, 16'h20);
    wr(4'd1, 16'h0077);
    @(negedge clk); cc_in[1] = 1'b1; idle(5);
    rd(4'd9, v); chk("R8 captured", v, 16'h0077);
    rd(4'd1, v); chk("R8 counter cleared", v, 16'h0000);
    @(negedge clk); cc_in[1] = 1'b0; idle(5);
    wr(4'd0, 16'h0); wr(4'd5, 16'h0);

    // R9 buffered capture on pair 0/2
    wr(4'd0, 16'h80);
    wr(4'd4, 16'h8);
    wr(4'd1, 16'h0100);
    @(negedge clk); cc_in[0] = 1'b1; idle(5);
    cc_in[0] = 1'b0; idle(5);
    wr(4'd1, 16'h0200);
    @(negedge clk); cc_in[0] = 1'b1; idle(5);
    cc_in[0] = 1'b0; idle(5);
    rd(4'd8, v);  chk("R9 newest capture", v, 16'h0200);
    rd(4'd10, v); chk("R9 buffer holds previous", v, 16'h0100);
    wr(4'd0, 16'h0); wr(4'd4, 16'h0);

    // R10 buffered compare: reload lands on the match tick
    wr(4'd4, 16'h5);
    for (int w = 1; w <= 2; w++) begin
      wr(4'd8, 16'd3); wr(4'd10, 16'd9); wr(4'd1, 16'h0);
      run_span(16'h80, w);
      rd(4'd8, v);
      chk($sformatf("R10 span %0d", w), v, (w == 2) ? 16'd9 : 16'd3);
    end
    rd(4'd10, v); chk("R10 buffer untouched", v, 16'd9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule